// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a successive-approximation converter. It picks a start event from one of five sources, controls when the sample switch follows the input, and runs a binary search against a one-bit comparator. It also produces a divided conversion clock, stores the finished code and raises a completion flag that can request an interrupt. The analog parts (trial DAC, comparator and input mux) sit outside the block. They see the trial code on `dac_o` and return their decision on `cmp_i`.

Software, two timer overflow strobes, an asynchronous convert-start pin, or a companion converter's software start can begin a conversion. There are two sampling policies. In the first, the input is followed at all times except during a conversion. In the second, a low-power policy, the input is followed only during a short window before the bit decisions, or only while the pin is low when the pin is the start source.

Top module: `sar_seq`

## Requirements
- R1: A conversion clock tick occurs every `sc_i`+1 system clocks, counted from the edge at which `busy_o` rises. In normal sampling a conversion holds `busy_o` high for exactly 8·(`sc_i`+1) clocks.
- R2: `mode_i` selects the start source: 0 selects `sw_start_i`, 1 selects `tmr3_ovf_i`, 2 selects a rising edge of `cnv_pin_i`, 3 selects `tmr2_ovf_i` and 4 selects `peer_start_i`. Codes 5 to 7 start nothing, and unselected sources have no effect.
- R3: `cnv_pin_i` goes through a two-flop synchronizer and an edge detector. A low-to-high change seen at clock edge j sets `busy_o` at edge j+2.
- R4: `busy_o` reads 1 from the edge that accepts a start until the conversion ends. A start event from any source while `busy_o` is 1 changes neither the length nor the result.
- R5: Bits are resolved MSB first, one per tick. Bit k is kept when `cmp_i` is 1 while `dac_o` carries the trial code. `result_o` changes only at the edge where `busy_o` falls.
- R6: `flag_o` is set at the edge where `busy_o` falls, even when `flag_clr_i` is high in that cycle. Otherwise it is cleared only by `flag_clr_i`. `irq_o` is high only while `flag_o` and `int_en_i` are both 1.
- R7: With `lp_track_i`=0, `track_o` is 1 whenever `busy_o` is 0 and `standby_i` is 0, and `track_o` is 0 throughout a conversion.
- R8: With `lp_track_i`=1 and a source other than the pin, `track_o` is 0 while idle. After a start it is 1 for exactly 3·(`sc_i`+1) clocks, and `busy_o` lasts 11·(`sc_i`+1) clocks.
- R9: With `lp_track_i`=1 and the pin selected, `track_o` follows the synchronized pin being low while idle. Conversion starts at the synchronized rising edge with no fixed window and lasts 8·(`sc_i`+1) clocks.
- R10: `standby_i` high forces `track_o` to 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sc_i | input | 5 | Conversion clock divide setting (divide by value+1) |
| mode_i | input | 3 | Start source select |
| lp_track_i | input | 1 | Low-power sampling policy enable |
| int_en_i | input | 1 | Interrupt enable |
| sw_start_i | input | 1 | Software start strobe (write of 1 to busy) |
| tmr3_ovf_i | input | 1 | Timer 3 overflow strobe |
| tmr2_ovf_i | input | 1 | Timer 2 overflow strobe |
| peer_start_i | input | 1 | Companion converter software start strobe |
| cnv_pin_i | input | 1 | Asynchronous convert-start pin |
| standby_i | input | 1 | Chip standby, disables sampling |
| flag_clr_i | input | 1 | Software clear of the completion flag |
| cmp_i | input | 1 | Comparator decision for current trial code |
| busy_o | output | 1 | Conversion in progress |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |
| track_o | output | 1 | Sample switch closed (input followed) |
| dac_o | output | 8 | Trial code for the external DAC |
| result_o | output | 8 | Last converted code |

## Verification
The hardest case to reach from the ports is a start event that arrives in the middle of a conversion. It must leave both the conversion length and the stored code unchanged. The bench raises every start strobe together at the second busy cycle of selected conversions and then compares the measured busy length and the result against values computed from `sc_i` and the modelled input voltage. A second hard case is a completion that lands while the flag clear is held high. The bench keeps `flag_clr_i` asserted through a whole conversion and samples the flag in the first idle cycle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    SM_SW   = 3'd0,
    SM_T3   = 3'd1,
    SM_PIN  = 3'd2,
    SM_T2   = 3'd3,
    SM_PEER = 3'd4
  } start_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRACK,
    ST_CONV
  } seq_state_e;
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // counter restarts with every conversion so tick phase is tied to the start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!run_i || (cnt_q == div_i))  cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == div_i);
endmodule

// File: rtl/sar_trig_sel.sv
module sar_trig_sel
  import sar_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       sw_i,
  input  logic       t3_i,
  input  logic       t2_i,
  input  logic       peer_i,
  input  logic       pin_i,
  output logic       trig_o,
  output logic       pin_lvl_o
);
  logic [2:0] pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= {pin_q[1:0], pin_i};
  end

  logic pin_rise;
  assign pin_rise  = pin_q[1] && !pin_q[2];
  assign pin_lvl_o = pin_q[1];

  always_comb begin
    unique case (mode_i)
      SM_SW:   trig_o = sw_i;
      SM_T3:   trig_o = t3_i;
      SM_PIN:  trig_o = pin_rise;
      SM_T2:   trig_o = t2_i;
      SM_PEER: trig_o = peer_i;
      default: trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_seq_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int TRACK_TICKS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pre_track_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             track_win_o,
  output logic             done_o,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] result_o
);
  localparam int IW = $clog2(RES_W);
  localparam int TW = $clog2(TRACK_TICKS) + 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(RES_W - 1);
  localparam logic [TW-1:0] LAST_TR = TW'(TRACK_TICKS - 1);

  seq_state_e       st_q;
  logic [RES_W-1:0] sar_q, res_q, trial, nxt;
  logic [IW-1:0]    idx_q;
  logic [TW-1:0]    tcnt_q;

  assign trial = sar_q | ({{(RES_W-1){1'b0}}, 1'b1} << idx_q);
  assign nxt   = cmp_i ? trial : sar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sar_q  <= '0;
      res_q  <= '0;
      idx_q  <= '0;
      tcnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (pre_track_i) begin
            st_q   <= ST_TRACK;
            tcnt_q <= '0;
          end else begin
            st_q  <= ST_CONV;
            sar_q <= '0;
            idx_q <= TOP_IDX;
          end
        end
        ST_TRACK: if (tick_i) begin
          if (tcnt_q == LAST_TR) begin
            st_q  <= ST_CONV;
            sar_q <= '0;
            idx_q <= TOP_IDX;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_CONV: if (tick_i) begin
          sar_q <= nxt;
          if (idx_q == '0) begin
            st_q  <= ST_IDLE;
            res_q <= nxt;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign track_win_o = (st_q == ST_TRACK);
  assign done_o      = (st_q == ST_CONV) && tick_i && (idx_q == '0);
  assign dac_o       = trial;
  assign result_o    = res_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int DIV_W       = 5,
  parameter int RES_W       = 8,
  parameter int TRACK_TICKS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] sc_i,
  input  logic [2:0]       mode_i,
  input  logic             lp_track_i,
  input  logic             int_en_i,
  input  logic             sw_start_i,
  input  logic             tmr3_ovf_i,
  input  logic             tmr2_ovf_i,
  input  logic             peer_start_i,
  input  logic             cnv_pin_i,
  input  logic             standby_i,
  input  logic             flag_clr_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             track_o,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] result_o
);
  logic trig, pin_lvl, tick, busy, done, track_win, pin_mode;

  sar_trig_sel i_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .sw_i     (sw_start_i),
    .t3_i     (tmr3_ovf_i),
    .t2_i     (tmr2_ovf_i),
    .peer_i   (peer_start_i),
    .pin_i    (cnv_pin_i),
    .trig_o   (trig),
    .pin_lvl_o(pin_lvl)
  );

  sar_clk_div #(.DIV_W(DIV_W)) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .div_i (sc_i),
    .tick_o(tick)
  );

  assign pin_mode = (mode_i == SM_PIN);

  sar_core #(.RES_W(RES_W), .TRACK_TICKS(TRACK_TICKS)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (trig && !busy),
    .pre_track_i(lp_track_i && !pin_mode),
    .tick_i     (tick),
    .cmp_i      (cmp_i),
    .busy_o     (busy),
    .track_win_o(track_win),
    .done_o     (done),
    .dac_o      (dac_o),
    .result_o   (result_o)
  );

  logic flag_q;
  // completion wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (done)       flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  always_comb begin
    if (standby_i)       track_o = 1'b0;
    else if (!lp_track_i) track_o = !busy;
    else if (pin_mode)   track_o = !busy && !pin_lvl;
    else                 track_o = track_win;
  end

  assign busy_o = busy;
  assign flag_o = flag_q;
  assign irq_o  = flag_q && int_en_i;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             int_en_i,
  input logic             flag_clr_i,
  input logic             track_o,
  input logic             standby_i,
  input logic             lp_track_i,
  input logic [RES_W-1:0] result_o
);
  p_flag_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> flag_o);

  p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  p_flag_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $fell(busy_o));

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (int_en_i && flag_o));

  p_result_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_o) |-> $stable(result_o));

  p_standby_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |-> !track_o);

  p_track_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lp_track_i && !busy_o && !standby_i) |-> track_o);

  p_hold_conv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lp_track_i && busy_o) |-> !track_o);
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) i_sar_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .int_en_i  (int_en_i),
  .flag_clr_i(flag_clr_i),
  .track_o   (track_o),
  .standby_i (standby_i),
  .lp_track_i(lp_track_i),
  .result_o  (result_o)
);

// File: tb/test_sar_seq.sv
`timescale 1ns/1ps
module test_sar_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] sc = '0;
  logic [2:0] mode = '0;
  logic       lp = 1'b0, int_en = 1'b0;
  logic       sw = 1'b0, t3 = 1'b0, t2 = 1'b0, peer = 1'b0, pin = 1'b0;
  logic       standby = 1'b0, fclr = 1'b0;
  logic [7:0] vin = '0;
  logic       cmp;
  logic       busy, flag, irq, track;
  logic [7:0] dac, result;

  int errors = 0;
  int checks = 0;
  bit done_run = 1'b0;

  always #2 clk = ~clk;

  assign cmp = (vin >= dac);

  sar_seq i_sar_seq (
    .clk_i(clk), .rst_ni(rst_n), .sc_i(sc), .mode_i(mode), .lp_track_i(lp),
    .int_en_i(int_en), .sw_start_i(sw), .tmr3_ovf_i(t3), .tmr2_ovf_i(t2),
    .peer_start_i(peer), .cnv_pin_i(pin), .standby_i(standby), .flag_clr_i(fclr),
    .cmp_i(cmp), .busy_o(busy), .flag_o(flag), .irq_o(irq), .track_o(track),
    .dac_o(dac), .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // raise source src (index equals its mode code) for one cycle; pin stays high
  task automatic fire(input int src);
    @(negedge clk);
    case (src)
      0: sw = 1'b1;
      1: t3 = 1'b1;
      2: pin = 1'b1;
      3: t2 = 1'b1;
      default: peer = 1'b1;
    endcase
    @(negedge clk);
    sw = 1'b0; t3 = 1'b0; t2 = 1'b0; peer = 1'b0;
  endtask

  // measure latency to busy, busy length, track cycles inside busy, result stability
  task automatic measure(input bit inject, output int lat, output int len,
                         output int trk, output bit res_stable);
    logic [7:0] prev;
    prev = result;
    lat = 0; len = 0; trk = 0; res_stable = 1'b1;
    while (!busy && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    while (busy) begin
      if (result !== prev) res_stable = 1'b0;
      if (track) trk++;
      len++;
      if (inject && len == 2) begin
        sw = 1'b1; t3 = 1'b1; t2 = 1'b1; peer = 1'b1;
      end else begin
        sw = 1'b0; t3 = 1'b0; t2 = 1'b0; peer = 1'b0;
      end
      @(negedge clk);
    end
    sw = 1'b0; t3 = 1'b0; t2 = 1'b0; peer = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); fclr = 1'b1;
    @(negedge clk); fclr = 1'b0;
  endtask

  task automatic conv(input int src, input int s, input bit lpm, input int v,
                      input bit inject, input int exp_lat, input int exp_len,
                      input int exp_trk, input string req);
    int lat, len, trk;
    bit st;
    sc = 5'(s); lp = lpm; mode = 3'(src); vin = 8'(v);
    pin = 1'b0;
    repeat (4) @(negedge clk);
    fire(src);
    measure(inject, lat, len, trk, st);
    chk(lat == exp_lat, {req, " start latency"}, lat, exp_lat);
    chk(len == exp_len, {req, " busy length"}, len, exp_len);
    chk(trk == exp_trk, {req, " track cycles"}, trk, exp_trk);
    chk(result == 8'(v), "R5 result", result, v);
    chk(st, "R5 result held during busy", 0, 1);
    chk(flag == 1'b1, "R6 flag set", flag, 1);
    chk(irq == int_en, "R6 irq gating", irq, int_en);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R4 no restart after inject", busy, 0);
    end
    pin = 1'b0;
    clear_flag();
    chk(flag == 1'b0, "R6 flag cleared", flag, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int started;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R4 reset busy", busy, 0);
    chk(flag == 0, "R6 reset flag", flag, 0);
    chk(result == 0, "R5 reset result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(track == 1, "R7 idle tracking", track, 1);
    standby = 1'b1;
    @(negedge clk);
    chk(track == 0, "R10 standby normal mode", track, 0);
    standby = 1'b0;

    // R5 full code sweep, software start, fastest clock
    int_en = 1'b1;
    for (int v = 0; v < 256; v++) conv(0, 0, 1'b0, v, 1'b0, 0, 8, 0, "R1");

    // R1 divider sweep, R8 low-power window
    for (int s = 0; s < 32; s += 5) begin
      conv(0, s, 1'b0, 8'h5A ^ s, 1'b0, 0, 8 * (s + 1), 0, "R1");
      conv(3, s, 1'b1, 8'hC3 ^ s, 1'b0, 0, 11 * (s + 1), 3 * (s + 1), "R8");
      conv(2, s, 1'b1, 8'h81 + s, 1'b0, 2, 8 * (s + 1), 0, "R9");
    end
    conv(4, 31, 1'b1, 8'hFF, 1'b0, 0, 11 * 32, 3 * 32, "R8");

    // R3 pin latency in normal mode, R4 injection under several dividers
    int_en = 1'b0;
    conv(2, 0, 1'b0, 8'h37, 1'b0, 2, 8, 0, "R3");
    for (int s = 0; s < 4; s++) begin
      conv(1, s, 1'b0, 8'h96 + s, 1'b1, 0, 8 * (s + 1), 0, "R4");
      conv(0, s, 1'b1, 8'h0F + s, 1'b1, 0, 11 * (s + 1), 3 * (s + 1), "R4");
    end

    // R2 every mode code against every source
    sc = '0; lp = 1'b0;
    for (int m = 0; m < 8; m++) begin
      for (int src = 0; src < 5; src++) begin
        mode = 3'(m);
        pin = 1'b0;
        repeat (4) @(negedge clk);
        fire(src);
        started = 0;
        for (int k = 0; k < 4; k++) begin
          if (busy) started = 1;
          @(negedge clk);
        end
        chk(started == ((m == src) ? 1 : 0), "R2 start source select",
            started, (m == src) ? 1 : 0);
        while (busy) @(negedge clk);
        pin = 1'b0;
        clear_flag();
      end
    end

    // R6 completion beats held clear
    mode = 3'd0; sc = 5'd1; lp = 1'b0;
    @(negedge clk); fclr = 1'b1;
    fire(0);
    while (busy) @(negedge clk);
    chk(flag == 1, "R6 set wins over clear", flag, 1);
    @(negedge clk);
    chk(flag == 0, "R6 clear after completion", flag, 0);
    fclr = 1'b0;

    // R8 idle in low-power non-pin mode, R9 pin-level tracking, R10 standby
    lp = 1'b1; mode = 3'd1;
    @(negedge clk);
    chk(track == 0, "R8 low-power idle hold", track, 0);
    mode = 3'd2; pin = 1'b0;
    repeat (3) @(negedge clk);
    chk(track == 1, "R9 pin low tracks", track, 1);
    standby = 1'b1;
    @(negedge clk);
    chk(track == 0, "R10 standby pin mode", track, 0);
    standby = 1'b0;
    mode = 3'd5; pin = 1'b1;
    repeat (3) @(negedge clk);
    mode = 3'd2;
    @(negedge clk);
    chk(track == 0, "R9 pin high holds", track, 0);
    chk(busy == 0, "R9 no start on level", busy, 0);
    pin = 1'b0;

    done_run = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule